// File: doc/BRIEF.md
# Multi-Channel Block-Copy DMA Engine

This block moves words between locations on a single memory port on behalf of several independent channels. Software programs three words for each channel: a source address, a destination address and a control word. The control word carries a unit count, a burst size, a request-line choice for each side, a per-side address-step flag, an interrupt enable, a channel enable and a start-mode flag. Each unit is one read beat followed by one write beat on the memory port. The port is a plain single-beat master: it holds its request, direction, address and write data until the slave raises ready.

In software-start mode the channel runs as soon as its enable bit is set. In hardware-start mode the channel waits for the peripheral request line chosen for each non-memory side. When that line is present, the channel moves one burst. It then raises the acknowledge of that line for a single cycle. When the last unit has gone, the channel drops its own enable bit and latches a done flag. The done flag feeds the shared interrupt line if the channel's interrupt is enabled. Several ready channels are served one burst at a time, and the lowest channel index always wins the next burst.

Top module: `dma_engine`

## Requirements
- R1: After reset every channel register and the done-status word read 0, and `mem_req`, `dma_ack` and `irq` are low.
- R2: Channel n's source address sits at byte offset 0x10*n, its destination address at 0x10*n+4 and its control word at 0x10*n+8. Each reads back what was last written. Control bits 31:28 always read 0.
- R3: The control word uses these fields: bit 0 start mode, bit 1 enable, bit 2 interrupt enable, bits 5:3 burst code, bit 6 destination step, bit 7 source step, bits 11:8 destination request select, bits 15:12 source request select and bits 27:16 unit count. With bit 0 = 1, setting bit 1 copies `count` words. For each unit the engine reads the source word and then writes that same value to the destination. It makes exactly 2*count memory accesses.
- R4: Each address moves up by 4 bytes after every unit when its step flag is 1 (bit 7 source, bit 6 destination). It stays fixed when the flag is 0.
- R5: Burst codes 0..4 give 1, 2, 4, 8 and 16 units per burst, and codes 5..7 give 16. The final burst of a transfer is cut short to the remaining count.
- R6: With bit 0 = 0, a burst starts only while every side whose select is 0..7 sees its `dma_req` line high. A select of 8..15 means plain memory with no handshake. While a needed line stays low, nothing moves.
- R7: In hardware-start mode, the cycle after each burst's last write raises the `dma_ack` bit of every peripheral side for exactly one cycle. No other `dma_ack` bit rises.
- R8: On completion the channel's enable bit reads 0 and its count field reads 0, while the other control fields keep their values. The addresses read their final values, and bit n of the status word at offset 0xF0 is 1.
- R9: `irq` is high while any channel has both its done bit and its interrupt enable set. Writing 1 to status bit n clears that bit. Writing 0 leaves it unchanged.
- R10: Arbitration happens only between bursts, and the lowest-indexed ready channel gets the next burst.
- R11: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R12: Enabling a channel with count 0 sets its done bit and clears its enable bit without any memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| dma_req | input | 8 | Peripheral request lines |
| dma_ack | output | 8 | Peripheral acknowledge pulses |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` on a read |
| mem_ready | input | 1 | Memory handshake completion |
| irq | output | 1 | Done interrupt |

## Verification
The hardest case to reach from the ports is two channels becoming ready in the same cycle while both sit in hardware-start mode. Only that situation shows whether the arbiter's choice follows index order rather than arrival order. The stimulus first enables both channels with their request lines held low, so each is fully armed but stalled. It then raises both lines in one step and checks which acknowledge rises first. The stalled interval also confirms that nothing moves while a line is low. Burst boundaries are otherwise invisible at the memory port. They are exposed by sweeping every burst code against a set of counts in hardware mode and counting acknowledge pulses against the ceiling of count over burst length.

// File: rtl/dma_pkg.sv
// Shared types for the DMA engine: control word layout, mover states
// and the burst-code decode. Assumes a 3-bit burst code and 4-bit selects.
package dma_pkg;

    localparam int CNT_W    = 12;
    localparam int SEL_W    = 4;
    localparam int NUM_REQ  = 8;
    localparam int CTRL_W   = 28;
    localparam int BLEN_W   = 5;

    // Control word, MSB first; bit 0 is start mode
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [SEL_W-1:0] src_sel;
        logic [SEL_W-1:0] dst_sel;
        logic             src_step;
        logic             dst_step;
        logic [2:0]       bcode;
        logic             irq_en;
        logic             enable;
        logic             sw_start;
    } ctrl_t;

    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_READ  = 2'd1,
        MV_WRITE = 2'd2,
        MV_ACK   = 2'd3
    } mv_state_e;

    // Units per burst for a burst code; codes above 4 saturate at 16
    function automatic logic [BLEN_W-1:0] burst_units(input logic [2:0] code);
        if (code > 3'd4)
            burst_units = BLEN_W'(16);
        else
            burst_units = BLEN_W'(1) << code;
    endfunction

    // A side is satisfied when it is memory or its request line is high
    function automatic logic side_ok(input logic [SEL_W-1:0] sel,
                                     input logic [NUM_REQ-1:0] lines);
        side_ok = sel[SEL_W-1] | lines[sel[2:0]];
    endfunction

endpackage

// File: rtl/dma_arb.sv
// Fixed-priority arbiter: lowest set request index wins.
// Assumes requests are sampled only when the caller is ready to grant.
module dma_arb #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] win,
    output logic             any
);

    // Scan from the top so the lowest requesting index is written last
    always_comb begin
        grant = '0;
        win   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                win      = IDX_W'(i);
            end
        end
    end

    // Any requester present
    assign any = |req;

endmodule

// File: rtl/dma_chan.sv
// One DMA channel: holds source, destination and control registers,
// advances them as the mover completes units, and keeps the done flag.
// Assumes the mover only pulses unit_done while this channel is granted.
module dma_chan
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_src,
    input  logic               wr_dst,
    input  logic               wr_ctrl,
    input  logic [31:0]        wr_data,
    input  logic               clr_done,
    input  logic               unit_done,
    input  logic [NUM_REQ-1:0] req_lines,
    output logic [ADDR_W-1:0]  src_addr,
    output logic [ADDR_W-1:0]  dst_addr,
    output ctrl_t              ctrl,
    output logic               ready,
    output logic               done
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    ctrl_t             ctrl_q;
    logic              done_q;
    logic              last_unit;
    logic              empty_start;
    logic              finish;

    assign last_unit   = unit_done && (ctrl_q.count == CNT_W'(1));
    assign empty_start = ctrl_q.enable && (ctrl_q.count == '0) && !unit_done;
    assign finish      = !wr_ctrl && ctrl_q.enable && (last_unit || empty_start);

    // Source address: software write or step after each unit
    always_ff @(posedge clk) begin
        if (!rst_n)
            src_q <= '0;
        else if (wr_src)
            src_q <= wr_data[ADDR_W-1:0];
        else if (unit_done && ctrl_q.src_step)
            src_q <= src_q + STEP;
    end

    // Destination address: software write or step after each unit
    always_ff @(posedge clk) begin
        if (!rst_n)
            dst_q <= '0;
        else if (wr_dst)
            dst_q <= wr_data[ADDR_W-1:0];
        else if (unit_done && ctrl_q.dst_step)
            dst_q <= dst_q + STEP;
    end

    // Control word: software write, count-down per unit, self-disable at end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end else begin
            if (unit_done)
                ctrl_q.count <= ctrl_q.count - CNT_W'(1);
            if (finish)
                ctrl_q.enable <= 1'b0;
        end
    end

    // Done flag: set on completion, cleared by a write of 1
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (finish)
            done_q <= 1'b1;
        else if (clr_done)
            done_q <= 1'b0;
    end

    // Ready for a burst: enabled, units left, start condition met
    always_comb begin
        ready = ctrl_q.enable && (ctrl_q.count != '0) &&
                (ctrl_q.sw_start ||
                 (side_ok(ctrl_q.src_sel, req_lines) &&
                  side_ok(ctrl_q.dst_sel, req_lines)));
    end

    assign src_addr = src_q;
    assign dst_addr = dst_q;
    assign ctrl     = ctrl_q;
    assign done     = done_q;

    // R3
    unit_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unit_done |-> (ctrl_q.enable && ctrl_q.count != '0))
        else $error("unit completed on an idle channel");

endmodule

// File: rtl/dma_mover.sv
// Shared data mover: picks a ready channel between bursts, runs each
// unit as a read then a write on the memory port, then acknowledges
// the peripherals of a hardware-started burst for one cycle.
// Assumes the memory slave completes each access by raising mem_ready.
module dma_mover
    import dma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CH-1:0]              chan_ready,
    input  logic [NUM_CH-1:0][ADDR_W-1:0]  src_addrs,
    input  logic [NUM_CH-1:0][ADDR_W-1:0]  dst_addrs,
    input  ctrl_t [NUM_CH-1:0]             ctrls,
    output logic [NUM_CH-1:0]              unit_done,
    output logic [NUM_REQ-1:0]             ack,
    output logic                           mem_req,
    output logic                           mem_we,
    output logic [ADDR_W-1:0]              mem_addr,
    output logic [DATA_W-1:0]              mem_wdata,
    input  logic [DATA_W-1:0]              mem_rdata,
    input  logic                           mem_ready
);

    mv_state_e         state_q;
    logic [IDX_W-1:0]  cur_q;
    logic [BLEN_W-1:0] left_q;
    logic [DATA_W-1:0] data_q;

    logic [NUM_CH-1:0] grant;
    logic [IDX_W-1:0]  win;
    logic              any;
    logic [BLEN_W-1:0] units;
    logic [BLEN_W-1:0] first_len;
    ctrl_t             win_ctrl;
    ctrl_t             cur_ctrl;

    dma_arb #(.N(NUM_CH), .IDX_W(IDX_W)) u_arb (
        .req   (chan_ready),
        .grant (grant),
        .win   (win),
        .any   (any)
    );

    assign win_ctrl = ctrls[win];
    assign cur_ctrl = ctrls[cur_q];

    // Burst length: coded size, trimmed to the units still owed
    always_comb begin
        units = burst_units(win_ctrl.bcode);
        if (win_ctrl.count < CNT_W'(units))
            first_len = win_ctrl.count[BLEN_W-1:0];
        else
            first_len = units;
    end

    // Sequencer: grant, read, write, repeat per unit, then acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MV_IDLE;
            cur_q   <= '0;
            left_q  <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                MV_IDLE: begin
                    if (any) begin
                        cur_q   <= win;
                        left_q  <= first_len;
                        state_q <= MV_READ;
                    end
                end
                MV_READ: begin
                    if (mem_ready) begin
                        data_q  <= mem_rdata;
                        state_q <= MV_WRITE;
                    end
                end
                MV_WRITE: begin
                    if (mem_ready) begin
                        left_q  <= left_q - BLEN_W'(1);
                        state_q <= (left_q == BLEN_W'(1)) ? MV_ACK : MV_READ;
                    end
                end
                default: state_q <= MV_IDLE;
            endcase
        end
    end

    // Memory port drive from the current state and granted channel
    always_comb begin
        mem_req   = (state_q == MV_READ) || (state_q == MV_WRITE);
        mem_we    = (state_q == MV_WRITE);
        mem_addr  = (state_q == MV_WRITE) ? dst_addrs[cur_q] : src_addrs[cur_q];
        mem_wdata = data_q;
    end

    // Unit completion strobe to the granted channel
    always_comb begin
        unit_done = '0;
        if (state_q == MV_WRITE && mem_ready)
            unit_done[cur_q] = 1'b1;
    end

    // Peripheral acknowledge after a hardware-started burst
    always_comb begin
        ack = '0;
        if (state_q == MV_ACK && !cur_ctrl.sw_start) begin
            if (!cur_ctrl.src_sel[SEL_W-1])
                ack[cur_ctrl.src_sel[2:0]] = 1'b1;
            if (!cur_ctrl.dst_sel[SEL_W-1])
                ack[cur_ctrl.dst_sel[2:0]] = 1'b1;
        end
    end

    // R10
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant))
        else $error("more than one channel granted");

    // R10
    grant_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~chan_ready) == '0)
        else $error("grant to a channel that is not ready");

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)))
        else $error("memory request changed before ready");

    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack) |=> (ack == '0))
        else $error("acknowledge held longer than one cycle");

    // R3
    unit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unit_done))
        else $error("unit completion to several channels");

    // R5
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MV_IDLE && any) |=>
            (left_q >= BLEN_W'(1) && left_q <= BLEN_W'(16)))
        else $error("burst length out of range");

endmodule

// File: rtl/dma_engine.sv
// Top of the DMA engine: decodes register writes and reads, instantiates
// one channel per NUM_CH and the shared mover, and forms the interrupt.
// Assumes NUM_CH is at most 15 so the status word at 0xF0 is free.
module dma_engine
    import dma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic [NUM_REQ-1:0] dma_req,
    output logic [NUM_REQ-1:0] dma_ack,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata,
    input  logic               mem_ready,
    output logic               irq
);

    localparam int         DATA_W   = 32;
    localparam int         IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [7:0] STAT_OFS = 8'hF0;

    logic [3:0] cfg_ch;
    logic [1:0] cfg_reg;
    logic       stat_hit;

    logic [NUM_CH-1:0][ADDR_W-1:0] src_addrs;
    logic [NUM_CH-1:0][ADDR_W-1:0] dst_addrs;
    ctrl_t [NUM_CH-1:0]            ctrls;
    logic [NUM_CH-1:0]             chan_ready;
    logic [NUM_CH-1:0]             chan_done;
    logic [NUM_CH-1:0]             unit_done;
    logic [NUM_CH-1:0]             irq_src;

    assign cfg_ch   = cfg_addr[7:4];
    assign cfg_reg  = cfg_addr[3:2];
    assign stat_hit = (cfg_addr == STAT_OFS);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = cfg_we && !stat_hit && (cfg_ch == 4'(i));

        dma_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_src    (sel && cfg_reg == 2'd0),
            .wr_dst    (sel && cfg_reg == 2'd1),
            .wr_ctrl   (sel && cfg_reg == 2'd2),
            .wr_data   (cfg_wdata),
            .clr_done  (cfg_we && stat_hit && cfg_wdata[i]),
            .unit_done (unit_done[i]),
            .req_lines (dma_req),
            .src_addr  (src_addrs[i]),
            .dst_addr  (dst_addrs[i]),
            .ctrl      (ctrls[i]),
            .ready     (chan_ready[i]),
            .done      (chan_done[i])
        );

        assign irq_src[i] = chan_done[i] && ctrls[i].irq_en;
    end

    dma_mover #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_mover (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_ready (chan_ready),
        .src_addrs  (src_addrs),
        .dst_addrs  (dst_addrs),
        .ctrls      (ctrls),
        .unit_done  (unit_done),
        .ack        (dma_ack),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready)
    );

    // Register read mux: status word or the addressed channel register
    always_comb begin
        cfg_rdata = '0;
        if (stat_hit) begin
            cfg_rdata = 32'(chan_done);
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (cfg_ch == 4'(i)) begin
                    case (cfg_reg)
                        2'd0:    cfg_rdata = 32'(src_addrs[i]);
                        2'd1:    cfg_rdata = 32'(dst_addrs[i]);
                        2'd2:    cfg_rdata = 32'(ctrls[i]);
                        default: cfg_rdata = '0;
                    endcase
                end
            end
        end
    end

    // Interrupt: any done channel with its interrupt enabled
    assign irq = |irq_src;

endmodule

// File: tb/dma_engine_test.sv
module dma_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [7:0]  dma_req = '0;
    logic [7:0]  dma_ack;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    dma_engine #(.NUM_CH(NCH), .ADDR_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dma_req(dma_req),
        .dma_ack(dma_ack), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- memory and peripheral models ----------------
    logic [31:0] mem [0:255];
    logic [7:0]  per_en = '0;
    int          init_tok = 0;
    int          init_seed = 0;
    int          seen_tok = 0;
    int          wait_left = 0;
    logic [7:0]  lfsr = 8'h5A;
    int          n_acc = 0;
    int          stab_err = 0;
    int          ack_cnt [0:7];
    logic        prev_pend = 1'b0;
    logic        prev_we = 1'b0;
    logic [31:0] prev_addr = '0;
    logic [31:0] prev_wd = '0;

    function automatic logic [31:0] pat(input int seed, input int i);
        pat = 32'h1000_0000 + (32'(seed) << 16) + 32'(i) * 32'h0101;
    endfunction

    initial for (int k = 0; k < 8; k++) ack_cnt[k] = 0;

    always @(negedge clk) begin
        if (init_tok != seen_tok) begin
            seen_tok = init_tok;
            for (int i = 0; i < 128; i++) mem[i] = pat(init_seed, i);
            for (int i = 128; i < 256; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
        end
        for (int k = 0; k < 8; k++) begin
            if (dma_ack[k]) begin
                ack_cnt[k] = ack_cnt[k] + 1;
                dma_req[k] = 1'b0;
            end else begin
                dma_req[k] = per_en[k];
            end
        end
        if (prev_pend && (!mem_req || mem_we != prev_we || mem_addr != prev_addr ||
                          (mem_we && mem_wdata != prev_wd)))
            stab_err = stab_err + 1;
        if (mem_req && !mem_ready) begin
            if (wait_left == 0) begin
                mem_ready = 1'b1;
                n_acc = n_acc + 1;
                if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[9:2]];
            end else begin
                wait_left = wait_left - 1;
            end
        end else begin
            mem_ready = 1'b0;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            wait_left = int'(lfsr[1:0]) % 3;
        end
        prev_pend = mem_req && !mem_ready;
        prev_we   = mem_we;
        prev_addr = mem_addr;
        prev_wd   = mem_wdata;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic init_mem(input int seed);
        init_seed = seed;
        init_tok  = init_tok + 1;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk(input int cnt, input int ss, input int ds,
                                       input bit si, input bit di, input int code,
                                       input bit ie, input bit en, input bit sw);
        mk = {4'b0, 12'(cnt), 4'(ss), 4'(ds), si, di, 3'(code), ie, en, sw};
    endfunction

    function automatic int units_of(input int code);
        units_of = (code > 4) ? 16 : (1 << code);
    endfunction

    task automatic wait_done(input int ch, input string tag);
        logic [31:0] s;
        int tries = 0;
        s = '0;
        while (!s[ch] && tries < 4000) begin
            rd(8'hF0, s);
            tries++;
        end
        chk(s[ch], tag, s, 32'(1) << ch);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] v;
        int cnts_sw [9] = '{1, 2, 3, 5, 8, 15, 16, 17, 20};
        int cnts_hw [5] = '{1, 3, 7, 16, 20};
        int seed = 1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(mem_req == 1'b0 && dma_ack == '0 && irq == 1'b0, "R1 outputs",
            {mem_req, dma_ack, irq}, 32'h0);
        for (int c = 0; c < NCH; c++) begin
            for (int r = 0; r < 3; r++) begin
                rd(8'(c * 16 + r * 4), v);
                chk(v == 32'h0, "R1 register", v, 32'h0);
            end
        end
        rd(8'hF0, v);
        chk(v == 32'h0, "R1 status", v, 32'h0);

        // R2: register map and readback
        wr(8'h20, 32'h1234_5678);
        wr(8'h24, 32'h9ABC_DEF0);
        wr(8'h28, 32'hFFFF_FFFD);
        rd(8'h20, v); chk(v == 32'h1234_5678, "R2 src ch2", v, 32'h1234_5678);
        rd(8'h24, v); chk(v == 32'h9ABC_DEF0, "R2 dst ch2", v, 32'h9ABC_DEF0);
        rd(8'h28, v); chk(v == 32'h0FFF_FFFD, "R2 ctrl ch2", v, 32'h0FFF_FFFD);
        wr(8'h28, 32'h0);

        // R3 R4 R5 R8 R9: software-start sweep on channel 0
        for (int code = 0; code < 8; code++) begin
            foreach (cnts_sw[j]) begin
                int cnt = cnts_sw[j];
                int acc0;
                bit ok;
                init_mem(seed);
                wr(8'h00, 32'h0000_0000);
                wr(8'h04, 32'h0000_0200);
                acc0 = n_acc;
                wr(8'h08, mk(cnt, 8, 8, 1, 1, code, 1, 1, 1));
                wait_done(0, "R8 done bit sw");
                ok = 1'b1;
                for (int i = 0; i < cnt; i++)
                    if (mem[128 + i] != pat(seed, i)) ok = 1'b0;
                chk(ok, "R3 copied data", 32'(cnt), 32'(code));
                chk(mem[128 + cnt] == (32'hDEAD_0000 | 32'(128 + cnt)), "R3 word past end",
                    mem[128 + cnt], 32'hDEAD_0000 | 32'(128 + cnt));
                chk(n_acc - acc0 == 2 * cnt, "R3 access count",
                    32'(n_acc - acc0), 32'(2 * cnt));
                rd(8'h08, v);
                chk(v == mk(0, 8, 8, 1, 1, code, 1, 0, 1), "R8 ctrl after",
                    v, mk(0, 8, 8, 1, 1, code, 1, 0, 1));
                rd(8'h00, v);
                chk(v == 32'(4 * cnt), "R4 src final", v, 32'(4 * cnt));
                rd(8'h04, v);
                chk(v == 32'h200 + 32'(4 * cnt), "R4 dst final", v, 32'h200 + 32'(4 * cnt));
                chk(irq == 1'b1, "R9 irq set", 32'(irq), 32'h1);
                wr(8'hF0, 32'h1);
                #1;
                chk(irq == 1'b0, "R9 irq cleared", 32'(irq), 32'h0);
                seed++;
            end
        end

        // R5 R7 R4: hardware-start sweep on channel 1, peripheral destination
        for (int code = 0; code < 8; code++) begin
            foreach (cnts_hw[j]) begin
                int cnt = cnts_hw[j];
                int a5;
                int others;
                int exp_b;
                init_mem(seed);
                for (int k = 0; k < 8; k++) if (k != 5) others += ack_cnt[k];
                a5 = ack_cnt[5];
                per_en[5] = 1'b1;
                wr(8'h10, 32'h0000_0000);
                wr(8'h14, 32'h0000_0300);
                wr(8'h18, mk(cnt, 8, 5, 1, 0, code, 0, 1, 0));
                wait_done(1, "R8 done bit hw");
                exp_b = (cnt + units_of(code) - 1) / units_of(code);
                chk(ack_cnt[5] - a5 == exp_b, "R5 R7 burst acks",
                    32'(ack_cnt[5] - a5), 32'(exp_b));
                for (int k = 0; k < 8; k++) if (k != 5) others -= ack_cnt[k];
                chk(others == 0, "R7 stray acks", 32'(others), 32'h0);
                chk(mem[192] == pat(seed, cnt - 1), "R4 fixed destination",
                    mem[192], pat(seed, cnt - 1));
                chk(mem[193] == 32'hDEAD_00C1, "R4 neighbour untouched",
                    mem[193], 32'hDEAD_00C1);
                rd(8'h14, v);
                chk(v == 32'h300, "R4 dst held", v, 32'h300);
                chk(irq == 1'b0, "R9 no irq when disabled", 32'(irq), 32'h0);
                per_en[5] = 1'b0;
                wr(8'hF0, 32'h2);
                seed++;
            end
        end

        // R6: hardware start stalls while the request line is low
        begin
            int acc0;
            bit ok;
            init_mem(seed);
            wr(8'h20, 32'h0000_0040);
            wr(8'h24, 32'h0000_0240);
            acc0 = n_acc;
            wr(8'h28, mk(4, 3, 9, 1, 1, 1, 0, 1, 0));
            repeat (50) @(negedge clk);
            chk(n_acc == acc0, "R6 no access while stalled", 32'(n_acc - acc0), 32'h0);
            rd(8'h28, v);
            chk(v == mk(4, 3, 9, 1, 1, 1, 0, 1, 0), "R6 ctrl unchanged",
                v, mk(4, 3, 9, 1, 1, 1, 0, 1, 0));
            per_en[3] = 1'b1;
            wait_done(2, "R6 done after request");
            per_en[3] = 1'b0;
            ok = 1'b1;
            for (int i = 0; i < 4; i++) if (mem[144 + i] != pat(seed, 16 + i)) ok = 1'b0;
            chk(ok, "R6 data after request", mem[144], pat(seed, 16));
            wr(8'hF0, 32'h4);
            seed++;
        end

        // R10: two armed channels released together; lower index first
        begin
            int b0, b1;
            int tries = 0;
            bit ok;
            init_mem(seed);
            wr(8'h00, 32'h0000_0000);
            wr(8'h04, 32'h0000_0200);
            wr(8'h10, 32'h0000_0100);
            wr(8'h14, 32'h0000_0280);
            wr(8'h08, mk(2, 0, 8, 1, 1, 0, 0, 1, 0));
            wr(8'h18, mk(2, 1, 8, 1, 1, 0, 0, 1, 0));
            b0 = ack_cnt[0];
            b1 = ack_cnt[1];
            @(negedge clk);
            per_en[0] = 1'b1;
            per_en[1] = 1'b1;
            while (ack_cnt[0] == b0 && ack_cnt[1] == b1 && tries < 500) begin
                @(posedge clk);
                tries++;
            end
            chk(ack_cnt[0] == b0 + 1 && ack_cnt[1] == b1, "R10 lower index first",
                32'(ack_cnt[1] - b1), 32'h0);
            wait_done(0, "R10 ch0 done");
            wait_done(1, "R10 ch1 done");
            per_en[0] = 1'b0;
            per_en[1] = 1'b0;
            ok = (mem[128] == pat(seed, 0)) && (mem[129] == pat(seed, 1)) &&
                 (mem[160] == pat(seed, 64)) && (mem[161] == pat(seed, 65));
            chk(ok, "R10 both copies", mem[160], pat(seed, 64));
            wr(8'hF0, 32'h3);
            seed++;
        end

        // R12 R9: zero count completes at once; write of 0 leaves done set
        begin
            int acc0;
            acc0 = n_acc;
            wr(8'h38, mk(0, 8, 8, 1, 1, 0, 1, 1, 1));
            repeat (2) @(negedge clk);
            rd(8'hF0, v);
            chk(v == 32'h8, "R12 done at once", v, 32'h8);
            chk(n_acc == acc0, "R12 no access", 32'(n_acc - acc0), 32'h0);
            rd(8'h38, v);
            chk(v == mk(0, 8, 8, 1, 1, 0, 1, 0, 1), "R12 enable cleared",
                v, mk(0, 8, 8, 1, 1, 0, 1, 0, 1));
            wr(8'hF0, 32'h0);
            rd(8'hF0, v);
            chk(v == 32'h8 && irq == 1'b1, "R9 write 0 no effect", v, 32'h8);
            wr(8'hF0, 32'h8);
            rd(8'hF0, v);
            chk(v == 32'h0 && irq == 1'b0, "R9 write 1 clears", v, 32'h0);
        end

        // R11: memory request held steady until ready throughout
        chk(stab_err == 0, "R11 request stability", 32'(stab_err), 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule